// File: doc/BRIEF.md
# Sequential Booth Multiplier with Early Termination

This block multiplies two 32-bit integers over several clock cycles. It recodes the multiplier operand in groups using Booth's method and adds one partial product per cycle into a running sum. The run stops as soon as the multiplier bits that are still unprocessed cannot change the sum. Small and sign-extended multipliers therefore finish in fewer cycles than large ones. The sum may start from an accumulate value instead of zero. The result is either the low 32 bits of the product or a full 64-bit product, and the 64-bit form treats the operands as signed or unsigned.

A build-time parameter picks the group width. The narrow build retires two multiplier bits per cycle and stops only when all remaining bits are zero. The wide build retires eight bits per cycle and also stops when all remaining bits are ones. The caller raises `start` for one cycle in idle, waits for the one-cycle `done` pulse and reads `result`. `cycles` reports how many cycles the operation took, so the latency can be checked.

Top module: `booth_mul_seq`

## Requirements
- R1: With `long_en` low, `result[31:0]` equals the low 32 bits of `op_a*op_b` (plus `acc_in[31:0]` when `acc_en` is high), `result[63:32]` is zero, and `signed_en` makes no difference.
- R2: With `long_en` high, `result` is the 64-bit product of `op_a` and `op_b`, both sign-extended when `signed_en` is high and zero-extended when it is low, plus the full 64-bit `acc_in` when `acc_en` is high.
- R3: `start` is taken only while `busy` is low. `busy` is high from the cycle after `start` until `done`, and a `start` seen while `busy` is high has no effect on the operation in flight.
- R4: `done` is high for exactly one cycle. `result` and `cycles` stay unchanged from that cycle until the next accepted `start`.
- R5: In the narrow build (EXT_MODE=0), let x be the multiplier extended to 64 bits as in R2, with a short operation treated as signed. `cycles` is 1 plus the smallest j ≥ 1 for which x shifted arithmetically right by 2j−1 is zero, or is all ones with 2j ≥ 32. A multiplier of 18 gives 4 and a multiplier of −1 gives 17.
- R6: In the wide build (EXT_MODE=1), `cycles` is 1 plus the smallest j ≥ 1 for which x shifted arithmetically right by 8j−1 is all zeros or all ones. The product 18 × −1 takes 2 cycles with either operand order, and no short operation takes more than 5.
- R7: An unsigned long operation whose multiplier has bit 31 set needs one extra group beyond the signed count: 18 cycles in the narrow build and 6 in the wide build.
- R8: After reset, `busy`, `done`, `result` and `cycles` are all zero.
- R9: With `acc_en` low, the value on `acc_in` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (idle only) |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier; its value sets the latency |
| acc_in | input | 2W | Value added to the product |
| acc_en | input | 1 | Add `acc_in` |
| long_en | input | 1 | 1: 64-bit result, 0: low 32 bits |
| signed_en | input | 1 | Signed operands for the 64-bit result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2W | Product (plus accumulate) |
| cycles | output | CYC_W | Cycle count of the last operation |

## Verification
The hardest case to reach is the extra Booth group that an unsigned long operation needs when bit 31 of the multiplier is set. The recoding reads the last 32-bit group as negative, and only a correction group above bit 31 restores the value. The stimulus reaches it with 0xFFFFFFFF and 0x80000000 as multipliers in every mix of signedness and width, and checks both the product and the longer count. A second `start` is also driven while an operation is running, with different operands and a different width select, to show that it is ignored.

// File: rtl/booth_mul_pkg.sv
// Shared definitions for the sequential Booth multiplier.
// Assumes: nothing beyond the parameter values passed to the functions.
package booth_mul_pkg;

    // Control phases: wait for start, extend operands, retire one group per cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PREP = 2'd1,
        PH_STEP = 2'd2
    } phase_e;

    // Multiplier bits retired per cycle for the chosen build.
    function automatic int grp_bits(input bit ext_mode);
        return ext_mode ? 8 : 2;
    endfunction

endpackage

// File: rtl/booth_recode.sv
// Booth recoder: turns one K-bit multiplier group plus the bit just below it
// into a signed digit = signed(group) + below_bit.
// Assumes: below_bit is 0 for the lowest group.
module booth_recode #(
    parameter int K = 2
) (
    input  logic [K-1:0] grp,
    input  logic         below,
    output logic [K:0]   digit
);
    // Sign-extend the group by one bit and add the incoming bit.
    assign digit = {grp[K-1], grp} + {{K{1'b0}}, below};
endmodule

// File: rtl/booth_pp.sv
// Partial-product generator: multiplicand (already shifted to the group
// position) times a signed Booth digit, modulo 2^PW.
// Assumes: digit is a two's-complement value of K+1 bits.
module booth_pp #(
    parameter int PW = 64,
    parameter int K  = 2
) (
    input  logic [PW-1:0] mcand,
    input  logic [K:0]    digit,
    output logic [PW-1:0] pp
);
    generate
        if (K == 2) begin : g_radix4
            // Radix-4 digit: select 0, +-M or +-2M without a multiplier.
            always_comb begin
                case (digit)
                    3'b001:  pp = mcand;
                    3'b010:  pp = mcand << 1;
                    3'b111:  pp = -mcand;
                    3'b110:  pp = -(mcand << 1);
                    default: pp = '0;
                endcase
            end
        end else begin : g_wide
            logic signed [PW-1:0] dext;
            // Wide digit: sign-extend and use a small signed product.
            assign dext = {{(PW-K-1){digit[K]}}, digit};
            assign pp   = $signed(mcand) * dext;
        end
    endgenerate
endmodule

// File: rtl/booth_stop_detect.sv
// Early-termination detector: decides whether the multiplier bits that are
// still unprocessed (plus the last processed bit, which Booth carries
// upward) contribute nothing more to the product.
// Assumes: rem_nx already holds the remaining bits, arithmetic-shifted.
module booth_stop_detect #(
    parameter bit EXT_MODE = 1'b0,
    parameter int RW       = 33,
    parameter int GCW      = 5,
    parameter int SGRP     = 16,
    parameter int MAXG     = 17
) (
    input  logic [RW-1:0]  rem_nx,
    input  logic           prev_nx,
    input  logic [GCW-1:0] grp_nx,
    output logic           stop
);
    logic zero_rest;
    logic ones_rest;
    logic cap_hit;

    // Remaining contribution is zero when all bits are zero, or all ones.
    assign zero_rest = (rem_nx == '0) && !prev_nx;
    assign ones_rest = (&rem_nx) && prev_nx;
    assign cap_hit   = (grp_nx == GCW'(MAXG));

    generate
        if (EXT_MODE) begin : g_both
            // Wide build: stop on either uniform pattern.
            assign stop = zero_rest || ones_rest || cap_hit;
        end else begin : g_zero_only
            // Narrow build: ones only end the run once every signed group is done.
            assign stop = zero_rest || cap_hit ||
                          (ones_rest && (grp_nx == GCW'(SGRP)));
        end
    endgenerate
endmodule

// File: rtl/booth_mul_seq.sv
// Sequential Booth multiplier with data-dependent early termination.
// One setup cycle extends the latched operands, then one multiplier group
// is retired per cycle until the detector sees no further contribution.
// Assumes: start is honoured only in idle; W is a multiple of the group width.
module booth_mul_seq
    import booth_mul_pkg::*;
#(
    parameter int W        = 32,
    parameter bit EXT_MODE = 1'b0,
    parameter int CYC_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [2*W-1:0]   acc_in,
    input  logic             acc_en,
    input  logic             long_en,
    input  logic             signed_en,
    output logic             busy,
    output logic             done,
    output logic [2*W-1:0]   result,
    output logic [CYC_W-1:0] cycles
);
    localparam int K    = grp_bits(EXT_MODE);
    localparam int PW   = 2 * W;
    localparam int RW   = W + 1;
    localparam int MAXG = (RW + K - 1) / K;
    localparam int SGRP = (W + K - 1) / K;
    localparam int GCW  = $clog2(MAXG + 1);

    phase_e          phase;
    logic [W-1:0]    a_q, b_q;
    logic [PW-1:0]   acc_q;
    logic            acce_q, long_q, sgn_q;
    logic [PW-1:0]   mcand_sh;
    logic [RW-1:0]   rem;
    logic            prev_q;
    logic [GCW-1:0]  grp_q;
    logic [PW-1:0]   prod;
    logic [PW-1:0]   res_q;
    logic            done_q;
    logic [CYC_W-1:0] cyc_q;

    logic            sgn_eff;
    logic [K:0]      digit;
    logic [PW-1:0]   pp;
    logic [PW-1:0]   prod_nx;
    logic [RW-1:0]   rem_nx;
    logic            prev_nx;
    logic [GCW-1:0]  grp_nx;
    logic            stop;

    // Short results are always taken as signed so that all-ones can end early.
    assign sgn_eff = sgn_q || !long_q;

    booth_recode #(.K(K)) u_recode (
        .grp   (rem[K-1:0]),
        .below (prev_q),
        .digit (digit)
    );

    booth_pp #(.PW(PW), .K(K)) u_pp (
        .mcand (mcand_sh),
        .digit (digit),
        .pp    (pp)
    );

    // Next-step values for the running sum and the multiplier shifter.
    assign prod_nx = prod + pp;
    assign rem_nx  = {{K{rem[RW-1]}}, rem[RW-1:K]};
    assign prev_nx = rem[K-1];
    assign grp_nx  = grp_q + 1'b1;

    booth_stop_detect #(
        .EXT_MODE (EXT_MODE),
        .RW       (RW),
        .GCW      (GCW),
        .SGRP     (SGRP),
        .MAXG     (MAXG)
    ) u_stop (
        .rem_nx  (rem_nx),
        .prev_nx (prev_nx),
        .grp_nx  (grp_nx),
        .stop    (stop)
    );

    // Control sequence: latch on start, extend, then step until the detector fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            a_q      <= '0;
            b_q      <= '0;
            acc_q    <= '0;
            acce_q   <= 1'b0;
            long_q   <= 1'b0;
            sgn_q    <= 1'b0;
            mcand_sh <= '0;
            rem      <= '0;
            prev_q   <= 1'b0;
            grp_q    <= '0;
            prod     <= '0;
            res_q    <= '0;
            done_q   <= 1'b0;
            cyc_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        a_q    <= op_a;
                        b_q    <= op_b;
                        acc_q  <= acc_in;
                        acce_q <= acc_en;
                        long_q <= long_en;
                        sgn_q  <= signed_en;
                        cyc_q  <= '0;
                        phase  <= PH_PREP;
                    end
                end
                PH_PREP: begin
                    mcand_sh <= {{W{sgn_eff & a_q[W-1]}}, a_q};
                    rem      <= {sgn_eff & b_q[W-1], b_q};
                    prev_q   <= 1'b0;
                    grp_q    <= '0;
                    prod     <= !acce_q ? '0 :
                                long_q  ? acc_q : {{W{1'b0}}, acc_q[W-1:0]};
                    cyc_q    <= CYC_W'(1);
                    phase    <= PH_STEP;
                end
                default: begin
                    prod     <= prod_nx;
                    mcand_sh <= mcand_sh << K;
                    rem      <= rem_nx;
                    prev_q   <= prev_nx;
                    grp_q    <= grp_nx;
                    cyc_q    <= cyc_q + 1'b1;
                    if (stop) begin
                        res_q  <= long_q ? prod_nx : {{W{1'b0}}, prod_nx[W-1:0]};
                        done_q <= 1'b1;
                        phase  <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy   = (phase != PH_IDLE);
    assign done   = done_q;
    assign result = res_q;
    assign cycles = cyc_q;
endmodule

// File: rtl/booth_mul_seq_chk.sv
// Protocol and latency checker for booth_mul_seq, attached by bind.
// Assumes: the same parameter values as the bound instance.
module booth_mul_seq_chk #(
    parameter int W        = 32,
    parameter bit EXT_MODE = 1'b0,
    parameter int CYC_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [2*W-1:0]   result,
    input logic [CYC_W-1:0] cycles
);
    localparam int K    = EXT_MODE ? 8 : 2;
    localparam int MAXC = 1 + (W + K) / K;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                               // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                               // R3
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                    // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result) && $stable(cycles)));   // R4
    AST_CYCLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles >= CYC_W'(2) && cycles <= CYC_W'(MAXC)));     // R5
endmodule

bind booth_mul_seq booth_mul_seq_chk #(
    .W        (W),
    .EXT_MODE (EXT_MODE),
    .CYC_W    (CYC_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .cycles (cycles)
);

// File: tb/booth_mul_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: one driver feeds both builds with the same operations,
// and a monitor per build pops expected products and counts.
module booth_mul_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [63:0] acc_in = '0;
    logic        acc_en = 1'b0, long_en = 1'b0, signed_en = 1'b0;

    logic        busy_b, done_b, busy_x, done_x;
    logic [63:0] res_b, res_x;
    logic [4:0]  cyc_b, cyc_x;

    int checks = 0, errors = 0, wd = 0, n_b = 0, n_x = 0;
    bit finished = 1'b0, pdone_b = 1'b0, pdone_x = 1'b0;
    logic [63:0] q_res_b[$], q_res_x[$];
    int          q_cyc_b[$], q_cyc_x[$];
    string       q_rt_b[$], q_rt_x[$], q_ct_b[$], q_ct_x[$];

    always #2.5 clk = ~clk;

    booth_mul_seq #(.W(32), .EXT_MODE(1'b0), .CYC_W(5)) u_booth_mul_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .acc_in(acc_in), .acc_en(acc_en), .long_en(long_en), .signed_en(signed_en),
        .busy(busy_b), .done(done_b), .result(res_b), .cycles(cyc_b));

    booth_mul_seq #(.W(32), .EXT_MODE(1'b1), .CYC_W(5)) u_booth_mul_seq_ext (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .acc_in(acc_in), .acc_en(acc_en), .long_en(long_en), .signed_en(signed_en),
        .busy(busy_x), .done(done_x), .result(res_x), .cycles(cyc_x));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic longint ext32(input logic [31:0] v, input bit s);
        if (s) return longint'($signed(v));
        return longint'({32'b0, v});
    endfunction

    function automatic logic [63:0] exp_res(input logic [31:0] a, b, input logic [63:0] acc,
                                            input bit ae, lg, sg);
        bit s = sg || !lg;
        longint p = ext32(a, s) * ext32(b, s);
        if (ae) p = p + (lg ? longint'(acc) : longint'({32'b0, acc[31:0]}));
        return lg ? p : {32'b0, p[31:0]};
    endfunction

    // Count from R5/R6: first j where the multiplier above bit K*j-1 is uniform.
    function automatic int exp_cyc(input logic [31:0] b, input bit s, input int k, input bit ext);
        longint x = ext32(b, s);
        for (int j = 1; j <= 40; j++) begin
            longint t = x >>> (k * j - 1);
            if (t == 0) return 1 + j;
            if (t == -1 && (ext || k * j >= 32)) return 1 + j;
        end
        return -1;
    endfunction

    // Monitors: compare each done pulse against the queue and check its width.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pdone_b) chk("R4 done width narrow", {63'b0, done_b}, 64'd0);
            if (pdone_x) chk("R4 done width wide", {63'b0, done_x}, 64'd0);
            if (done_b) begin
                if (q_res_b.size() == 0) chk("R3 unexpected done narrow", 64'd1, 64'd0);
                else begin
                    chk(q_rt_b.pop_front(), res_b, q_res_b.pop_front());
                    chk(q_ct_b.pop_front(), {59'b0, cyc_b}, 64'(q_cyc_b.pop_front()));
                end
                n_b++;
            end
            if (done_x) begin
                if (q_res_x.size() == 0) chk("R3 unexpected done wide", 64'd1, 64'd0);
                else begin
                    chk(q_rt_x.pop_front(), res_x, q_res_x.pop_front());
                    chk(q_ct_x.pop_front(), {59'b0, cyc_x}, 64'(q_cyc_x.pop_front()));
                end
                n_x++;
            end
        end
        pdone_b = done_b;
        pdone_x = done_x;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL R3 watchdog: actual %0d cycles expected completion", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver: push expectations, pulse start, optionally retry start while busy.
    task automatic do_op(input logic [31:0] a, b, input logic [63:0] acc,
                         input bit ae, lg, sg, input bit overlap, input string rtag);
        logic [63:0] er = exp_res(a, b, acc, ae, lg, sg);
        bit s = sg || !lg;
        int cb = exp_cyc(b, s, 2, 1'b0);
        int cx = exp_cyc(b, s, 8, 1'b1);
        int tb = n_b + 1, tx = n_x + 1;
        string rt = (rtag != "") ? rtag : (!ae && acc != 0) ? "R9" : lg ? "R2" : "R1";
        bool_t: begin end
        q_res_b.push_back(er); q_res_x.push_back(er);
        q_cyc_b.push_back(cb); q_cyc_x.push_back(cx);
        q_rt_b.push_back({rt, " narrow result"}); q_rt_x.push_back({rt, " wide result"});
        q_ct_b.push_back((lg && !sg && b[31]) ? "R7 narrow count" : "R5 narrow count");
        q_ct_x.push_back((lg && !sg && b[31]) ? "R7 wide count" : "R6 wide count");
        @(negedge clk);
        op_a = a; op_b = b; acc_in = acc; acc_en = ae; long_en = lg; signed_en = sg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (overlap) begin
            @(negedge clk);
            op_a = ~a; op_b = b ^ 32'h00FF_0F0F; acc_in = ~acc; long_en = !lg;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (n_b >= tb && n_x >= tx);
        repeat (3) @(negedge clk);
        chk("R4 narrow hold", res_b, er);
        chk("R4 wide hold", res_x, er);
        chk("R4 narrow count hold", {59'b0, cyc_b}, 64'(cb));
        chk("R4 wide count hold", {59'b0, cyc_x}, 64'(cx));
    endtask

    initial begin
        logic [31:0] corners [8];
        corners = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
                    32'd18, 32'd1, 32'd2, 32'h0000_0100};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state of both builds
        chk("R8 busy", {62'b0, busy_b, busy_x}, 64'd0);
        chk("R8 done", {62'b0, done_b, done_x}, 64'd0);
        chk("R8 result", res_b | res_x, 64'd0);
        chk("R8 cycles", {54'b0, cyc_b, cyc_x}, 64'd0);

        // R5/R6 examples: 18 x -1 in both operand orders
        do_op(32'd18, 32'hFFFF_FFFF, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, "");
        do_op(32'hFFFF_FFFF, 32'd18, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, "");
        // R7: unsigned long with top multiplier bit set, with accumulate
        do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, "");
        do_op(32'h1234_5678, 32'h8000_0000, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0, "");
        // R9: accumulate value present but disabled
        do_op(32'hDEAD_BEEF, 32'h0000_0303, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, 1'b1, 1'b0, "");
        do_op(32'h0000_0007, 32'h0000_0009, 64'h5555_AAAA_5555_AAAA, 1'b0, 1'b0, 1'b0, 1'b0, "");
        // R3: start while busy is ignored
        do_op(32'hCAFE_0001, 32'h7FFF_FFFF, 64'd99, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
        do_op(32'h8000_0000, 32'h8000_0000, 64'd5, 1'b1, 1'b1, 1'b1, 1'b1, "R3");

        // Corner cross product with rotating width, signedness and accumulate
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                do_op(corners[i], corners[j], {$urandom(), $urandom()},
                      ((i * j) % 3) == 0, ((i + j) % 2) == 1, (((i + j) / 2) % 2) == 1,
                      1'b0, "");
            end
        end
        // Random operands
        for (int n = 0; n < 60; n++) begin
            logic [31:0] rb = $urandom();
            if (n % 4 == 1) rb = rb >> ($urandom() % 32);
            if (n % 4 == 2) rb = rb | (32'hFFFF_FFFF << ($urandom() % 32));
            do_op($urandom(), rb, {$urandom(), $urandom()},
                  $urandom() % 2 == 1, $urandom() % 2 == 1, $urandom() % 2 == 1, 1'b0, "");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule